// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block turns a single operation request into the exact series of write cycles that a parallel NOR flash device needs to accept a command. A request carries an opcode, a target address and a data word, and is launched with a one-clock start strobe. The sequencer then issues the write cycles one after another on a simple bus master port. Each cycle is held until the bus answers with ready. The sequence depends on the opcode. Most operations open with a two-cycle unlock prefix. A few use one cycle only.

Command addresses are offsets from a fixed device base. A width input picks how they are scaled. A 16-bit device on a byte-addressed bus gets the offset shifted left by one. An 8-bit device gets it unshifted. User-supplied addresses (program target, sector address) pass through unchanged. When the last cycle has been accepted, the block raises done for one clock. The block only issues commands. Checking whether the flash has finished a program or erase is left to a separate polling block.

Top module: `nor_cmd_seq`

## Requirements
- R1: After synchronous reset, busy, done, reject and bus_wr are all low.
- R2: Opcodes are coded 0 reset-to-read, 1 read-ID, 2 program, 3 sector erase, 4 chip erase, 5 CFI query. Opcodes 1 to 4 begin with the unlock pair: data 0xAA at command offset 0x555, then data 0x55 at offset 0x2AA.
- R3: Read-ID is three cycles in total. Its third cycle writes 0x90 at offset 0x555.
- R4: Program is four cycles. Its third cycle writes 0xA0 at offset 0x555, and its fourth writes the request data at the request address.
- R5: Sector erase is six cycles. After the unlock pair it writes 0x80@0x555, 0xAA@0x555 and 0x55@0x2AA, and finally 0x30 at the request address.
- R6: Chip erase has the same first five cycles as sector erase. Its sixth cycle writes 0x10 at offset 0x555.
- R7: Reset-to-read is one cycle that writes 0xF0 at the device base address (offset 0).
- R8: CFI query is one cycle that writes 0x98 at offset 0x55, with no unlock prefix.
- R9: A command cycle's bus address is the device base plus the offset. The offset is shifted left by one bit when wide_dev was high at start, and left unshifted otherwise. Request addresses are never scaled.
- R10: While bus_wr is high and bus_ready is low, bus_wr, bus_addr and bus_wdata hold their values into the next cycle.
- R11: Done is high for exactly one clock, in the clock after the last cycle is accepted. Busy is low in that same clock.
- R12: A start seen while busy produces a one-clock reject in the following clock. The operation in progress continues with its cycle sequence unchanged.
- R13: A start with opcode 6 or 7 while idle produces a one-clock reject, and the block issues no bus cycle and stays not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | One-clock request strobe |
| req_op | input | 3 | Operation code |
| req_addr | input | AW | Target byte address (program / sector erase) |
| req_data | input | DW | Program data word |
| wide_dev | input | 1 | 1 = 16-bit device, command offsets shifted by one |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock pulse after the last cycle |
| reject | output | 1 | One-clock pulse for a refused request |
| bus_addr | output | AW | Bus write address |
| bus_wdata | output | DW | Bus write data |
| bus_wr | output | 1 | Bus write request, held until ready |
| bus_ready | input | 1 | Bus accepts the current write |

## Verification
A wrong step index or a wrong captured opcode shows up on the bus at the first cycle it affects, as an unexpected address or data word. It can also show up as a sequence that is too long or too short, which becomes visible when done arrives. A wrong handshake state shows within one clock of a stalled cycle, as a moved address or a dropped write strobe. A wrong idle/active state shows at once, as a missing or spurious reject or as bus_wr high while the block is not busy.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    localparam int IDX_W     = 3;
    localparam int OFF_W     = 12;
    localparam int MAX_STEPS = 6;

    typedef enum logic [2:0] {
        OP_RESET = 3'd0,
        OP_ID    = 3'd1,
        OP_PROG  = 3'd2,
        OP_SECT  = 3'd3,
        OP_CHIP  = 3'd4,
        OP_CFI   = 3'd5
    } seq_op_e;

    typedef enum logic { ST_IDLE = 1'b0, ST_ACTIVE = 1'b1 } seq_state_e;

    typedef struct packed {
        logic             user_addr;
        logic             user_data;
        logic [OFF_W-1:0] off;
        logic [7:0]       code;
        logic             last;
    } step_t;

    function automatic logic op_legal(input logic [2:0] op);
        return op <= 3'd5;
    endfunction

    function automatic step_t step_of(input seq_op_e op, input logic [IDX_W-1:0] idx);
        step_t s;
        s = '{user_addr: 1'b0, user_data: 1'b0, off: '0, code: 8'h00, last: 1'b1};
        case (op)
            OP_RESET: s.code = 8'hF0;
            OP_CFI: begin
                s.off  = 12'h055;
                s.code = 8'h98;
            end
            default: begin
                s.last = 1'b0;
                case (idx)
                    3'd0: begin s.off = 12'h555; s.code = 8'hAA; end
                    3'd1: begin s.off = 12'h2AA; s.code = 8'h55; end
                    3'd2: begin
                        s.off = 12'h555;
                        if (op == OP_ID)        begin s.code = 8'h90; s.last = 1'b1; end
                        else if (op == OP_PROG) s.code = 8'hA0;
                        else                    s.code = 8'h80;
                    end
                    3'd3: begin
                        if (op == OP_PROG) begin
                            s.user_addr = 1'b1;
                            s.user_data = 1'b1;
                            s.last      = 1'b1;
                        end else begin
                            s.off  = 12'h555;
                            s.code = 8'hAA;
                        end
                    end
                    3'd4: begin s.off = 12'h2AA; s.code = 8'h55; end
                    default: begin
                        s.last = 1'b1;
                        if (op == OP_SECT) begin
                            s.user_addr = 1'b1;
                            s.code      = 8'h30;
                        end else begin
                            s.off  = 12'h555;
                            s.code = 8'h10;
                        end
                    end
                endcase
            end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/nor_seq_step.sv
module nor_seq_step
    import nor_seq_pkg::*;
#(
    parameter int          AW       = 24,
    parameter int          DW       = 16,
    parameter logic [AW-1:0] DEV_BASE = '0
) (
    input  seq_op_e              op,
    input  logic [IDX_W-1:0]     idx,
    input  logic                 wide,
    input  logic [AW-1:0]        usr_addr,
    input  logic [DW-1:0]        usr_data,
    output logic [AW-1:0]        addr,
    output logic [DW-1:0]        wdata,
    output logic                 last
);
    localparam int PAD_N = AW - OFF_W;

    step_t         st;
    logic [AW-1:0] off_ext;
    logic [AW-1:0] scaled;

    always_comb begin
        st      = step_of(op, idx);
        off_ext = {{PAD_N{1'b0}}, st.off};
        scaled  = wide ? (off_ext << 1) : off_ext;
        addr    = st.user_addr ? usr_addr : (DEV_BASE + scaled);
        wdata   = st.user_data ? usr_data : {{(DW-8){1'b0}}, st.code};
        last    = st.last;
    end

endmodule

// File: rtl/nor_seq_fsm.sv
module nor_seq_fsm
    import nor_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             legal,
    input  logic             last,
    input  logic             ready,
    output logic             active,
    output logic             load,
    output logic [IDX_W-1:0] idx,
    output logic             done,
    output logic             reject
);
    seq_state_e state;

    assign active = (state == ST_ACTIVE);
    assign load   = start && (state == ST_IDLE) && legal;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            idx    <= '0;
            done   <= 1'b0;
            reject <= 1'b0;
        end else begin
            done   <= 1'b0;
            reject <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (legal) begin
                            state <= ST_ACTIVE;
                            idx   <= '0;
                        end else begin
                            reject <= 1'b1;
                        end
                    end
                end
                default: begin
                    if (start) reject <= 1'b1;
                    if (ready) begin
                        if (last) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int            AW       = 24,
    parameter int            DW       = 16,
    parameter logic [AW-1:0] DEV_BASE = 24'h400000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_start,
    input  logic [2:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    input  logic          wide_dev,
    output logic          busy,
    output logic          done,
    output logic          reject,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic          bus_wr,
    input  logic          bus_ready
);
    seq_op_e          op_q;
    logic [AW-1:0]    addr_q;
    logic [DW-1:0]    data_q;
    logic             wide_q;
    logic             active;
    logic             load;
    logic             last;
    logic [IDX_W-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= OP_RESET;
            addr_q <= '0;
            data_q <= '0;
            wide_q <= 1'b0;
        end else if (load) begin
            op_q   <= seq_op_e'(req_op);
            addr_q <= req_addr;
            data_q <= req_data;
            wide_q <= wide_dev;
        end
    end

    nor_seq_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .start  (req_start),
        .legal  (op_legal(req_op)),
        .last   (last),
        .ready  (bus_ready),
        .active (active),
        .load   (load),
        .idx    (idx),
        .done   (done),
        .reject (reject)
    );

    nor_seq_step #(.AW(AW), .DW(DW), .DEV_BASE(DEV_BASE)) u_step (
        .op       (op_q),
        .idx      (idx),
        .wide     (wide_q),
        .usr_addr (addr_q),
        .usr_data (data_q),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .last     (last)
    );

    assign busy   = active;
    assign bus_wr = active;

endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk #(
    parameter int AW = 24,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          req_start,
    input logic [2:0]    req_op,
    input logic          busy,
    input logic          done,
    input logic          reject,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic          bus_wr,
    input logic          bus_ready
);
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_ready) |=> (bus_wr && $stable(bus_addr) && $stable(bus_wdata)));

    a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r11_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r12_reject_busy: assert property (@(posedge clk) disable iff (rst)
        (req_start && busy) |=> reject);

    a_r13_illegal: assert property (@(posedge clk) disable iff (rst)
        (req_start && !busy && req_op > 3'd5) |=> (reject && !busy));

    a_r13_no_idle_write: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !bus_wr);

    a_r12_reject_cause: assert property (@(posedge clk) disable iff (rst)
        reject |-> $past(req_start));
endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_start (req_start),
    .req_op    (req_op),
    .busy      (busy),
    .done      (done),
    .reject    (reject),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_ready (bus_ready)
);

// File: tb/nor_cmd_seq_test.sv
module nor_cmd_seq_test;
    localparam int          AW   = 24;
    localparam int          DW   = 16;
    localparam logic [23:0] BASE = 24'h400000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_start = 1'b0;
    logic [2:0]    req_op = 3'd0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic          wide_dev = 1'b0;
    logic          busy, done, reject, bus_wr;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic          bus_ready = 1'b1;

    always #5 clk = ~clk;

    nor_cmd_seq uut (
        .clk(clk), .rst(rst), .req_start(req_start), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .wide_dev(wide_dev),
        .busy(busy), .done(done), .reject(reject), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_ready(bus_ready)
    );

    int checks = 0;
    int fails  = 0;

    task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // bus monitor and ready generator, all on the falling edge
    logic          stall_en = 1'b0;
    int            ncnt = 0;
    int            log_n = 0;
    logic [AW-1:0] log_a [8];
    logic [DW-1:0] log_d [8];
    int            last_acc = 0;
    int            done_cnt = 0;
    int            done_at = 0;
    logic          busy_at_done = 1'b0;
    logic          prev_stalled = 1'b0;
    logic [AW-1:0] prev_a = '0;
    logic [DW-1:0] prev_d = '0;

    always @(negedge clk) begin
        logic rdy;
        ncnt++;
        rdy = !stall_en || (ncnt % 3 == 0);
        bus_ready = rdy;
        if (bus_wr && prev_stalled)
            check((bus_addr == prev_a) && (bus_wdata == prev_d), "R10 stall hold",
                  {bus_addr, bus_wdata}, {prev_a, prev_d});
        prev_stalled = bus_wr && !rdy;
        prev_a = bus_addr;
        prev_d = bus_wdata;
        if (bus_wr && rdy) begin
            if (log_n < 8) begin
                log_a[log_n] = bus_addr;
                log_d[log_n] = bus_wdata;
            end
            log_n++;
            last_acc = ncnt;
        end
        if (done) begin
            done_cnt++;
            done_at = ncnt;
            busy_at_done = busy;
        end
    end

    function automatic logic [23:0] cmd(input logic w, input logic [11:0] off);
        return BASE + (w ? {11'd0, off, 1'b0} : {12'd0, off});
    endfunction

    // expected sequence written from the requirements
    task automatic expect_seq(input logic [2:0] op, input logic w, input logic [23:0] a,
                              input logic [15:0] d, output int n,
                              output logic [23:0] ea [8], output logic [15:0] ed [8]);
        for (int i = 0; i < 8; i++) begin ea[i] = '0; ed[i] = '0; end
        n = 0;
        if (op == 3'd0) begin ea[0] = BASE; ed[0] = 16'h00F0; n = 1; end
        else if (op == 3'd5) begin ea[0] = cmd(w, 12'h055); ed[0] = 16'h0098; n = 1; end
        else begin
            ea[0] = cmd(w, 12'h555); ed[0] = 16'h00AA;
            ea[1] = cmd(w, 12'h2AA); ed[1] = 16'h0055;
            if (op == 3'd1) begin ea[2] = cmd(w, 12'h555); ed[2] = 16'h0090; n = 3; end
            else if (op == 3'd2) begin
                ea[2] = cmd(w, 12'h555); ed[2] = 16'h00A0;
                ea[3] = a; ed[3] = d; n = 4;
            end else begin
                ea[2] = cmd(w, 12'h555); ed[2] = 16'h0080;
                ea[3] = cmd(w, 12'h555); ed[3] = 16'h00AA;
                ea[4] = cmd(w, 12'h2AA); ed[4] = 16'h0055;
                if (op == 3'd3) begin ea[5] = a; ed[5] = 16'h0030; end
                else begin ea[5] = cmd(w, 12'h555); ed[5] = 16'h0010; end
                n = 6;
            end
        end
    endtask

    function automatic string op_tag(input logic [2:0] op, input int i);
        if (i < 2 && op != 3'd0 && op != 3'd5) return "R2 unlock";
        case (op)
            3'd0: return "R7 reset";
            3'd1: return "R3 read-id";
            3'd2: return "R4 program";
            3'd3: return "R5 sector erase";
            3'd4: return "R6 chip erase";
            default: return "R8 cfi";
        endcase
    endfunction

    task automatic launch(input logic [2:0] op, input logic w, input logic [23:0] a, input logic [15:0] d);
        @(negedge clk);
        req_op = op; wide_dev = w; req_addr = a; req_data = d; req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        wide_dev = ~w;
    endtask

    task automatic wait_done(input int d0);
        int t = 0;
        while (done_cnt == d0 && t < 200) begin @(negedge clk); t++; end
        @(negedge clk);
    endtask

    task automatic compare_log(input logic [2:0] op, input logic w, input logic [23:0] a, input logic [15:0] d);
        int n;
        logic [23:0] ea [8];
        logic [15:0] ed [8];
        expect_seq(op, w, a, d, n, ea, ed);
        check(log_n == n, "R11 cycle count", 64'(log_n), 64'(n));
        for (int i = 0; i < n && i < log_n; i++) begin
            check(log_a[i] == ea[i], w ? "R9 wide addr" : op_tag(op, i), 64'(log_a[i]), 64'(ea[i]));
            check(log_d[i] == ed[i], op_tag(op, i), 64'(log_d[i]), 64'(ed[i]));
        end
    endtask

    // {op, wide, stall, addr, data}
    localparam logic [44:0] VEC [9] = '{
        {3'd1, 1'b0, 1'b0, 24'h000000, 16'h0000},
        {3'd2, 1'b1, 1'b1, 24'h012346, 16'hBEEF},
        {3'd3, 1'b0, 1'b1, 24'h420000, 16'h0000},
        {3'd4, 1'b1, 1'b0, 24'h000000, 16'h0000},
        {3'd0, 1'b0, 1'b0, 24'h000000, 16'h0000},
        {3'd5, 1'b1, 1'b0, 24'h000000, 16'h0000},
        {3'd5, 1'b0, 1'b1, 24'h000000, 16'h0000},
        {3'd2, 1'b0, 1'b0, 24'h4000FE, 16'h1234},
        {3'd1, 1'b1, 1'b1, 24'h000000, 16'h0000}
    };

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !reject && !bus_wr, "R1 reset state",
              {busy, done, reject, bus_wr}, 4'b0000);

        for (int v = 0; v < 9; v++) begin
            logic [2:0]  op;
            logic        w, s;
            logic [23:0] a;
            logic [15:0] d;
            int          d0;
            {op, w, s, a, d} = VEC[v];
            stall_en = s;
            log_n = 0;
            d0 = done_cnt;
            launch(op, w, a, d);
            wait_done(d0);
            compare_log(op, w, a, d);
            check(done_cnt == d0 + 1, "R11 single done", 64'(done_cnt - d0), 64'd1);
            check(done_at == last_acc + 1, "R11 done timing", 64'(done_at), 64'(last_acc + 1));
            check(!busy_at_done, "R11 busy low at done", 64'(busy_at_done), 64'd0);
        end

        // R12: start while a sector erase is running
        begin
            int d0;
            stall_en = 1'b1;
            log_n = 0;
            d0 = done_cnt;
            launch(3'd3, 1'b0, 24'h430000, 16'h0000);
            @(negedge clk);
            req_op = 3'd4; req_start = 1'b1;
            @(negedge clk);
            req_start = 1'b0;
            check(reject === 1'b1, "R12 reject while busy", 64'(reject), 64'd1);
            check(busy === 1'b1, "R12 still busy", 64'(busy), 64'd1);
            wait_done(d0);
            compare_log(3'd3, 1'b0, 24'h430000, 16'h0000);
        end

        // R13: illegal opcodes 6 and 7
        for (int k = 6; k < 8; k++) begin
            stall_en = 1'b0;
            log_n = 0;
            @(negedge clk);
            req_op = 3'(k); req_start = 1'b1;
            @(negedge clk);
            req_start = 1'b0;
            check(reject === 1'b1, "R13 illegal reject", 64'(reject), 64'd1);
            check(busy === 1'b0, "R13 illegal not busy", 64'(busy), 64'd0);
            repeat (4) @(negedge clk);
            check(log_n == 0, "R13 no bus cycles", 64'(log_n), 64'd0);
        end

        // R1: reset in the middle of an operation
        stall_en = 1'b1;
        launch(3'd4, 1'b0, 24'h0, 16'h0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(!busy && !done && !reject && !bus_wr, "R1 reset mid-op",
              {busy, done, reject, bus_wr}, 4'b0000);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule